// File: doc/BRIEF.md
# Smartcard Character Transceiver

This block moves single characters over the one-wire, half-duplex data line of a contact smartcard. The line is open-drain: the block only pulls it low and otherwise leaves it to a pull-up. Both directions share one line. A byte offered on the transmit handshake is sent as a start bit, eight data bits, an even parity bit and guard time. A character arriving from the card is sampled at the middle of each bit and presented on the receive handshake, together with a parity-error flag for the framing layer above.

All timing is counted in card-clock cycles, one cycle of `clk_i` per card clock. The elementary time unit (one bit period) is fixed at 372 cycles after reset. Once the framing layer signals that the answer-to-reset is over, the bit period becomes the negotiated F/D ratio, which is 32 cycles for F=512 and D=16.

The first character received after reset selects the line convention. In inverse convention every data and parity bit is complemented on the line and bytes travel most-significant bit first. Transmit start times are spaced by a programmable character wait time.

Top module: `sc_char_if`

## Requirements
- R1: After reset, tx_ready_o is 1, rx_valid_o is 0, io_pull_o is 0 and conv_inv_o is 0 (direct convention).
- R2: While atr_done_i is 0, one bit period lasts 372 clk_i cycles, so the transmitted start bit holds the line low for exactly 372 cycles.
- R3: While atr_done_i is 1, one bit period lasts fd_ratio_i cycles (at least 2).
- R4: A transmitted character consists of a start bit (line low), 8 data bits, and a parity bit that makes the count of ones over data and parity even. These are followed by at least 2 bit periods of released line. In direct convention the line carries data bit 0 first and a 1 as high.
- R5: If the first character received after reset has the raw line pattern 0x03 when read least-significant bit first without inversion, the block switches to inverse convention. That character is delivered as 0x3F. In inverse convention every data and parity bit is complemented on the line and sent most-significant bit first, in both directions; the start bit stays low. Any other first character (such as 0x3B) keeps direct convention. conv_inv_o stays set until reset.
- R6: rx_perr_o is 1 together with a received character whose decoded data and parity bits hold an odd count of ones, and 0 otherwise.
- R7: With tx_valid_i held high, successive transmit accepts are spaced by exactly max(12, cwt_i) bit periods plus one cycle.
- R8: A falling edge on the line starts reception only if the line is still low half a bit period later; a shorter low pulse produces no character.
- R9: While a character is being transmitted, the receiver ignores the line; the transmitter does not accept a byte while a reception is in progress.
- R10: A byte is accepted on a cycle with tx_valid_i and tx_ready_o both high. rx_valid_o stays high until a cycle with rx_ready_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| atr_done_i | input | 1 | Selects the negotiated bit period |
| fd_ratio_i | input | 16 | Negotiated cycles per bit (F/D) |
| cwt_i | input | 8 | Transmit start-to-start spacing in bit periods |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_data_i | input | 8 | Transmit byte |
| tx_ready_o | output | 1 | Transmitter can accept a byte |
| rx_valid_o | output | 1 | Received byte available |
| rx_data_o | output | 8 | Received byte, decoded |
| rx_perr_o | output | 1 | Parity error on the received byte |
| rx_ready_i | input | 1 | Received byte consumed |
| conv_inv_o | output | 1 | Inverse convention in use |
| io_i | input | 1 | Sensed level of the data line |
| io_pull_o | output | 1 | Pull the data line low |

## Verification
The bench goes after the convention decision. It sends the inverse initial character and checks that later characters are bit-reversed and complemented in both directions; a design that missed the switch would deliver 0x03 and garble every later byte. After a second reset, a 0x3B initial character must leave direct convention in place. The bench measures start-bit width before and after atr_done_i, which catches a bit timer stuck at 372 or off by one. It measures start-to-start spacing with cwt_i both above and below the frame length, which catches a missing floor or an off-by-one in the wait counter. Two further probes target the receiver: a sub-half-period glitch must yield no character, so a receiver that starts on a bare falling edge would emit a spurious byte; and line activity during transmission must never surface as a received character.

// File: rtl/sc_char_pkg.sv
package sc_char_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned CHAR_BITS = DATA_W + 2;          // start + data + parity
  localparam int unsigned GUARD_ETU = 2;
  localparam int unsigned FRAME_ETU = CHAR_BITS + GUARD_ETU;
  localparam logic [DATA_W-1:0] TS_INV_RAW = 8'h03;        // 0x3F seen through direct decoding

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_state_e;

  function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = d[DATA_W-1-i];
    return r;
  endfunction

  // line bits, index 0 sent first
  function automatic logic [CHAR_BITS-1:0] enc_char(input logic [DATA_W-1:0] d, input logic inv);
    logic [CHAR_BITS-1:0] f;
    f[0] = 1'b0;
    f[DATA_W:1] = inv ? ~bit_rev(d) : d;
    f[CHAR_BITS-1] = inv ? ~(^d) : ^d;
    return f;
  endfunction

  function automatic logic [DATA_W-1:0] dec_data(input logic [DATA_W-1:0] raw, input logic inv);
    return inv ? ~bit_rev(raw) : raw;
  endfunction
endpackage

// File: rtl/sc_etu_cnt.sv
module sc_etu_cnt #(
  parameter int unsigned ETU_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [ETU_W-1:0] lim_i,
  output logic             tick_o
);
  logic [ETU_W-1:0] cnt_q;

  // >= keeps the counter bounded if the limit shrinks mid-count
  assign tick_o = (cnt_q >= lim_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || tick_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
  import sc_char_pkg::*;
#(
  parameter int unsigned ETU_W = 16,
  parameter int unsigned CWT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ETU_W-1:0]  etu_i,
  input  logic [CWT_W-1:0]  cwt_i,
  input  logic              inv_i,
  input  logic              rx_busy_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              tx_busy_o,
  output logic              tx_fire_o,
  output logic              pull_o
);
  localparam logic [CWT_W-1:0] FRAME_LIM = CWT_W'(FRAME_ETU);
  localparam logic [CWT_W-1:0] BITS_LIM  = CWT_W'(CHAR_BITS);

  logic                 active_q;
  logic [CHAR_BITS-1:0] frame_q;
  logic [CWT_W-1:0]     etu_n_q, span_q, span_d;
  logic                 tick;

  assign tx_ready_o = !active_q && !rx_busy_i;
  assign tx_fire_o  = tx_valid_i && tx_ready_o;
  assign tx_busy_o  = active_q;
  assign pull_o     = active_q && !frame_q[0];
  assign span_d     = (cwt_i < FRAME_LIM) ? FRAME_LIM : cwt_i;

  sc_etu_cnt #(.ETU_W(ETU_W)) u_etu (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(!active_q),
    .lim_i  (etu_i),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      frame_q  <= '1;
      etu_n_q  <= '0;
      span_q   <= FRAME_LIM;
    end else if (tx_fire_o) begin
      active_q <= 1'b1;
      frame_q  <= enc_char(tx_data_i, inv_i);
      etu_n_q  <= '0;
      span_q   <= span_d;
    end else if (active_q && tick) begin
      frame_q <= {1'b1, frame_q[CHAR_BITS-1:1]};
      etu_n_q <= etu_n_q + 1'b1;
      if (etu_n_q == span_q - 1'b1) active_q <= 1'b0;
    end
  end

  AST_TX_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fire_o |=> pull_o); // R4
  AST_TX_GUARD_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && etu_n_q >= BITS_LIM) |-> !pull_o); // R4
  AST_TX_SPAN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> ($past(etu_n_q) == $past(span_q) - 1'b1)); // R7
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
  import sc_char_pkg::*;
#(
  parameter int unsigned ETU_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ETU_W-1:0]  etu_i,
  input  logic              tx_hold_i,
  input  logic              line_i,
  input  logic              rx_ready_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_perr_o,
  output logic              rx_busy_o,
  output logic              conv_inv_o
);
  localparam logic [3:0] LAST_BIT = 4'(CHAR_BITS - 2);

  rx_state_e            state_q;
  logic [1:0]           sync_q;
  logic                 prev_q, line_s, fall;
  logic [3:0]           bit_n_q;
  logic [CHAR_BITS-2:0] raw_q, raw_d;
  logic                 first_q, conv_q, inv_eff, done;
  logic [ETU_W-1:0]     lim;
  logic                 tick;

  assign line_s     = sync_q[1];
  assign fall       = prev_q && !line_s;
  assign lim        = (state_q == RX_START) ? (etu_i >> 1) : etu_i;
  assign raw_d      = {line_s, raw_q[CHAR_BITS-2:1]};
  assign done       = (state_q == RX_DATA) && tick && (bit_n_q == LAST_BIT);
  assign inv_eff    = conv_q || (first_q && raw_d[DATA_W-1:0] == TS_INV_RAW);
  assign rx_busy_o  = (state_q != RX_IDLE);
  assign conv_inv_o = conv_q;

  sc_etu_cnt #(.ETU_W(ETU_W)) u_etu (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(state_q == RX_IDLE),
    .lim_i  (lim),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      prev_q <= line_s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      bit_n_q <= '0;
      raw_q   <= '0;
    end else begin
      unique case (state_q)
        RX_IDLE:  if (fall && !tx_hold_i) state_q <= RX_START;
        RX_START: if (tick) begin
          state_q <= line_s ? RX_IDLE : RX_DATA;
          bit_n_q <= '0;
        end
        RX_DATA:  if (tick) begin
          raw_q   <= raw_d;
          bit_n_q <= bit_n_q + 1'b1;
          if (bit_n_q == LAST_BIT) state_q <= RX_IDLE;
        end
        default:  state_q <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
      rx_perr_o  <= 1'b0;
      first_q    <= 1'b1;
      conv_q     <= 1'b0;
    end else if (done) begin
      rx_valid_o <= 1'b1;
      rx_data_o  <= dec_data(raw_d[DATA_W-1:0], inv_eff);
      rx_perr_o  <= (^raw_d) ^ inv_eff;
      first_q    <= 1'b0;
      conv_q     <= inv_eff;
    end else if (rx_ready_i) begin
      rx_valid_o <= 1'b0;
    end
  end

  AST_RX_IGNORE_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_IDLE && tx_hold_i) |=> (state_q == RX_IDLE)); // R9
  AST_RX_START_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && tick && line_s) |=> (state_q == RX_IDLE)); // R8
  AST_RX_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> rx_valid_o); // R10
  AST_CONV_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_inv_o |=> conv_inv_o); // R5
endmodule

// File: rtl/sc_char_if.sv
module sc_char_if
  import sc_char_pkg::*;
#(
  parameter int unsigned ETU_W   = 16,
  parameter int unsigned CWT_W   = 8,
  parameter int unsigned DEF_ETU = 372
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              atr_done_i,
  input  logic [ETU_W-1:0]  fd_ratio_i,
  input  logic [CWT_W-1:0]  cwt_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_perr_o,
  input  logic              rx_ready_i,
  output logic              conv_inv_o,
  input  logic              io_i,
  output logic              io_pull_o
);
  localparam logic [ETU_W-1:0] ETU_RESET = ETU_W'(DEF_ETU);

  logic [ETU_W-1:0] etu;
  logic             tx_busy, tx_fire, rx_busy;

  assign etu = atr_done_i ? fd_ratio_i : ETU_RESET;

  sc_char_tx #(.ETU_W(ETU_W), .CWT_W(CWT_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .etu_i     (etu),
    .cwt_i     (cwt_i),
    .inv_i     (conv_inv_o),
    .rx_busy_i (rx_busy),
    .tx_valid_i(tx_valid_i),
    .tx_data_i (tx_data_i),
    .tx_ready_o(tx_ready_o),
    .tx_busy_o (tx_busy),
    .tx_fire_o (tx_fire),
    .pull_o    (io_pull_o)
  );

  sc_char_rx #(.ETU_W(ETU_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .etu_i     (etu),
    .tx_hold_i (tx_busy || tx_fire),
    .line_i    (io_i),
    .rx_ready_i(rx_ready_i),
    .rx_valid_o(rx_valid_o),
    .rx_data_o (rx_data_o),
    .rx_perr_o (rx_perr_o),
    .rx_busy_o (rx_busy),
    .conv_inv_o(conv_inv_o)
  );

  AST_HALF_DUPLEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_busy && rx_busy)); // R9
  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!io_pull_o && !rx_valid_o)); // R1
endmodule

// File: tb/sc_char_if_bench.sv
`timescale 1ns/1ps
module sc_char_if_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        atr_done = 1'b0;
  logic [15:0] fd_ratio = 16'd32;
  logic [7:0]  cwt = 8'd25;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_ready, rx_valid, rx_perr, conv_inv, io_pull;
  logic [7:0]  rx_data;
  logic        rx_ready = 1'b0;
  logic        card_pull = 1'b0;
  wire         line = !(io_pull || card_pull);  // open-drain line with pull-up

  int n_cmp = 0, n_bad = 0, cyc = 0, t_acc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sc_char_if u_sc_char_if (
    .clk_i(clk), .rst_ni(rst_n), .atr_done_i(atr_done), .fd_ratio_i(fd_ratio),
    .cwt_i(cwt), .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_perr_o(rx_perr),
    .rx_ready_i(rx_ready), .conv_inv_o(conv_inv), .io_i(line), .io_pull_o(io_pull)
  );

  // {corrupt parity, byte}
  localparam logic [8:0] VEC [0:7] = '{9'h000, 9'h0FF, 9'h1A5, 9'h03C,
                                       9'h080, 9'h101, 9'h05A, 9'h1E7};

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic card_send(input logic [7:0] d, input bit inv, input int etu, input bit badp);
    logic [9:0] b;
    b[0] = 1'b0;
    for (int i = 0; i < 8; i++) b[i+1] = inv ? ~d[7-i] : d[i];
    b[9] = (inv ? ~(^d) : ^d) ^ badp;
    for (int i = 0; i < 10; i++) begin
      card_pull = !b[i];
      repeat (etu) @(negedge clk);
    end
    card_pull = 1'b0;
    repeat (2*etu) @(negedge clk);
  endtask

  task automatic rx_expect(input string req, input logic [7:0] d, input bit perr);
    chk({req, " rx_valid"}, int'(rx_valid), 1);
    chk({req, " rx_data"}, int'(rx_data), int'(d));
    chk({req, " rx_perr"}, int'(rx_perr), int'(perr));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk({req, " rx_valid cleared"}, int'(rx_valid), 0);  // R10
  endtask

  task automatic tx_send(input logic [7:0] d);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data = d;
    while (!tx_ready) @(negedge clk);
    t_acc = cyc;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic tx_capture(input bit inv, input int etu, output logic [7:0] d, output bit par_ok);
    logic [9:0] b;
    while (line) @(negedge clk);
    repeat (etu/2) @(negedge clk);
    b[0] = line;
    for (int i = 1; i < 10; i++) begin
      repeat (etu) @(negedge clk);
      b[i] = line;
    end
    for (int i = 0; i < 8; i++)
      if (inv) d[7-i] = ~b[i+1]; else d[i] = b[i+1];
    par_ok = (b[0] == 1'b0) && ((^d) == (inv ? ~b[9] : b[9]));
  endtask

  task automatic wait_idle();
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic tx_roundtrip(input string req, input logic [7:0] d, input bit inv, input int etu);
    logic [7:0] got;
    bit ok;
    fork
      tx_send(d);
      tx_capture(inv, etu, got, ok);
    join
    wait_idle();
    chk({req, " tx data"}, int'(got), int'(d));
    chk({req, " tx parity"}, int'(ok), 1);
  endtask

  task automatic start_width(output int w);
    w = 0;
    fork
      tx_send(8'h55);
      begin
        while (line) @(negedge clk);
        while (!line) begin w++; @(negedge clk); end
      end
    join
    wait_idle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w, t1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_ready", int'(tx_ready), 1);
    chk("R1 rx_valid", int'(rx_valid), 0);
    chk("R1 io_pull", int'(io_pull), 0);
    chk("R1 conv_inv", int'(conv_inv), 0);

    // R5 inverse initial character at the reset bit period
    card_send(8'h3F, 1'b1, 372, 1'b0);
    rx_expect("R5 inverse TS", 8'h3F, 1'b0);
    chk("R5 conv_inv set", int'(conv_inv), 1);

    // R2 default bit period
    start_width(w);
    chk("R2 start bit width", w, 372);

    // R3 negotiated bit period
    atr_done = 1'b1;
    fd_ratio = 16'd32;
    start_width(w);
    chk("R3 start bit width", w, 32);

    // vector table, inverse convention: R5 R6 R4
    foreach (VEC[i]) begin
      card_send(VEC[i][7:0], 1'b1, 32, VEC[i][8]);
      rx_expect("R6 R5 rx vector", VEC[i][7:0], VEC[i][8]);
      tx_roundtrip("R4 R5 tx vector", VEC[i][7:0], 1'b1, 32);
    end

    // R7 spacing with cwt above and below the frame length
    cwt = 8'd25;
    tx_send(8'h11); t1 = t_acc;
    tx_send(8'h22);
    chk("R7 spacing cwt=25", t_acc - t1, 25*32 + 1);
    wait_idle();
    cwt = 8'd4;
    tx_send(8'h33); t1 = t_acc;
    tx_send(8'h44);
    chk("R7 spacing floor", t_acc - t1, 12*32 + 1);
    wait_idle();

    // R8 glitch shorter than half a bit
    repeat (64) @(negedge clk);
    card_pull = 1'b1;
    repeat (8) @(negedge clk);
    card_pull = 1'b0;
    repeat (14*32) @(negedge clk);
    chk("R8 glitch rejected", int'(rx_valid), 0);
    card_send(8'hC3, 1'b1, 32, 1'b0);
    rx_expect("R8 after glitch", 8'hC3, 1'b0);

    // R9 card activity during transmit
    fork
      tx_send(8'hA5);
      begin
        repeat (3*32) @(negedge clk);
        card_pull = 1'b1;
        repeat (64) @(negedge clk);
        card_pull = 1'b0;
      end
    join
    wait_idle();
    repeat (3*32) @(negedge clk);
    chk("R9 ignored during tx", int'(rx_valid), 0);

    // R5 direct initial character after a fresh reset
    rst_n = 1'b0;
    atr_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 conv_inv after reset", int'(conv_inv), 0);
    card_send(8'h3B, 1'b0, 372, 1'b0);
    rx_expect("R5 direct TS", 8'h3B, 1'b0);
    chk("R5 conv stays direct", int'(conv_inv), 0);
    tx_roundtrip("R4 R2 direct tx", 8'h96, 1'b0, 372);
    atr_done = 1'b1;
    card_send(8'h5E, 1'b0, 32, 1'b1);
    rx_expect("R6 direct parity error", 8'h5E, 1'b1);
    tx_roundtrip("R4 R3 direct tx", 8'h01, 1'b0, 32);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule